// File: doc/BRIEF.md
# I2C Slave Address Match Receiver

This block is the target side of a two-wire serial bus. It samples the clock and data lines through a synchronizer and finds start and stop conditions on the sampled values. After a start it shifts in the first byte with the most significant bit first, then compares the upper seven bits with a programmed own address. On a match it acknowledges on the ninth clock, raises the addressed flag and takes the transfer direction from the lowest bit of that byte. It then receives or sends whole bytes, each followed by an acknowledge bit.

The block drives no bus line high. It has one output, `sda_pull`, that turns on an open-drain pull-down on the data line. Software sets the own address and supplies each byte to send on `tx_byte`. The last received byte, or the address byte, is visible on `rx_data`.

States: IDLE (bus free), ADDR (shift address), ADDR_ACK (drive address acknowledge), RX_DATA / RX_ACK (receive byte, acknowledge it), TX_DATA / TX_ACK (send byte, sample master acknowledge), IGNORE (not addressed or transmission ended). Transitions: a start goes from any state to ADDR; a stop goes from any state to IDLE; ADDR goes to ADDR_ACK on a match or to IGNORE on a mismatch at the eighth clock fall; ADDR_ACK goes to TX_DATA or RX_DATA at the ninth clock fall; RX_DATA goes to RX_ACK at the eighth fall, and RX_ACK goes back to RX_DATA at the next fall; TX_DATA goes to TX_ACK at the eighth fall; TX_ACK goes to TX_DATA if the master pulled the line low, or to IGNORE otherwise.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, `bus_busy`, `addressed`, `transmitting` and `sda_pull` are all 0.
- R2: A start condition (data falls while clock is high) sets `bus_busy` to 1 and clears `transmitting` and `addressed` to 0.
- R3: The first byte after a start is shifted in MSB first; bits [7:1] are compared with `own_addr`. On a match `addressed` becomes 1 and the data line is held low for the whole high phase of the ninth clock.
- R4: After a match, `transmitting` takes bit 0 of the address byte (1 = the master reads, the slave sends).
- R5: On a mismatch the slave gives no acknowledge, `addressed` stays 0, and it pulls the data line on no later bit until the next start or stop.
- R6: In receive mode each data byte is shifted MSB first into `rx_data` and acknowledged on its ninth clock. `rx_data` holds the byte during that acknowledge.
- R7: In transmit mode the slave sends `tx_byte` MSB first and pulls the line for each 0 bit. When the master acknowledges (line low on the ninth clock), `tx_byte` is loaded as the next byte.
- R8: In transmit mode, a master no-acknowledge (line high on the ninth clock) ends the transfer. `sda_pull` then stays 0 until the next start.
- R9: A stop condition (data rises while clock is high) clears `bus_busy`, `addressed` and `transmitting`.
- R10: A start that arrives in the middle of a data byte cancels it. The next byte is taken as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| own_addr | input | 7 | Programmed slave address |
| tx_byte | input | 8 | Next byte to send in transmit mode |
| sda_pull | output | 1 | 1 turns on the pull-down on the data line |
| addressed | output | 1 | The slave has been addressed |
| transmitting | output | 1 | 1 when the slave sends, 0 when it receives |
| bus_busy | output | 1 | Set between a start and a stop |
| rx_data | output | 8 | Shift register holding the last received byte |

## Verification
A start condition can be detected in the same cycle that the FSM would otherwise handle a data bit or an acknowledge edge. The start must win: the byte is dropped and `transmitting` and `addressed` are cleared. The bench provokes this by issuing a repeated start after three bits of a data byte to an addressed slave. It then sends a new read address and checks that the bits shift from the start of that address and that the direction follows the new read/write bit. The second overlap is a stop arriving while the slave is in IGNORE or right after a no-acknowledge. It is judged by `bus_busy` and `addressed` both reading 0 and `sda_pull` staying released.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_DATA,
        ST_RX_ACK,
        ST_TX_DATA,
        ST_TX_ACK,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    localparam int LINES = 2;

    logic [LINES-1:0]  raw_bus;
    logic [STAGES-1:0] chain [LINES];
    logic [LINES-1:0]  cur;
    logic [LINES-1:0]  prev;

    assign raw_bus = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= '1;
                prev[g]  <= 1'b1;
            end else begin
                chain[g] <= {chain[g][STAGES-2:0], raw_bus[g]};
                prev[g]  <= chain[g][STAGES-1];
            end
        end
        assign cur[g] = chain[g][STAGES-1];
    end

    assign scl_s    = cur[0];
    assign sda_s    = cur[1];
    assign scl_rise = cur[0] & ~prev[0];
    assign scl_fall = ~cur[0] & prev[0];
    assign start_c  = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign stop_c   = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_pull,
    output logic              addressed,
    output logic              transmitting,
    output logic              bus_busy,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    slv_state_t        st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] txsh;
    logic              ack_ok;
    logic              byte_end;
    logic              match;

    assign byte_end = scl_fall && (cnt == LAST_BIT);
    assign match    = (shreg[DATA_W-1 -: ADDR_W] == own_addr);
    assign rx_data  = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (start_c) begin
            st_nx = ST_ADDR;
        end else if (stop_c) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_nx = ST_IDLE;
                ST_ADDR:     if (byte_end) st_nx = match ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) st_nx = transmitting ? ST_TX_DATA : ST_RX_DATA;
                ST_RX_DATA:  if (byte_end) st_nx = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) st_nx = ST_RX_DATA;
                ST_TX_DATA:  if (byte_end) st_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) st_nx = ack_ok ? ST_TX_DATA : ST_IGNORE;
                ST_IGNORE:   st_nx = ST_IGNORE;
                default:     st_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            shreg        <= '0;
            txsh         <= '0;
            ack_ok       <= 1'b0;
            sda_pull     <= 1'b0;
            addressed    <= 1'b0;
            transmitting <= 1'b0;
            bus_busy     <= 1'b0;
        end else if (start_c) begin
            cnt          <= '0;
            sda_pull     <= 1'b0;
            addressed    <= 1'b0;
            transmitting <= 1'b0;
            bus_busy     <= 1'b1;
        end else if (stop_c) begin
            cnt          <= '0;
            sda_pull     <= 1'b0;
            addressed    <= 1'b0;
            transmitting <= 1'b0;
            bus_busy     <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_RX_DATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end
                    if (byte_end) begin
                        cnt <= '0;
                        if (st == ST_RX_DATA) begin
                            sda_pull <= 1'b1;
                        end else if (match) begin
                            addressed    <= 1'b1;
                            transmitting <= shreg[0];
                            sda_pull     <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (transmitting) begin
                            txsh     <= tx_byte;
                            sda_pull <= ~tx_byte[DATA_W-1];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) sda_pull <= 1'b0;
                end
                ST_TX_DATA: begin
                    if (scl_rise) cnt <= cnt + 1'b1;
                    if (byte_end) begin
                        cnt      <= '0;
                        sda_pull <= 1'b0;
                    end else if (scl_fall) begin
                        txsh     <= txsh << 1;
                        sda_pull <= ~txsh[DATA_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) ack_ok <= ~sda_s;
                    if (scl_fall) begin
                        cnt <= '0;
                        if (ack_ok) begin
                            txsh     <= tx_byte;
                            sda_pull <= ~tx_byte[DATA_W-1];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_pull,
    output logic              addressed,
    output logic              transmitting,
    output logic              bus_busy,
    output logic [DATA_W-1:0] rx_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2c_slv_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_c      (start_c),
        .stop_c       (stop_c),
        .own_addr     (own_addr),
        .tx_byte      (tx_byte),
        .sda_pull     (sda_pull),
        .addressed    (addressed),
        .transmitting (transmitting),
        .bus_busy     (bus_busy),
        .rx_data      (rx_data)
    );
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_c,
    input logic stop_c,
    input logic sda_pull,
    input logic addressed,
    input logic transmitting,
    input logic bus_busy
);
    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (bus_busy && !transmitting && !addressed));

    p_clear_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!bus_busy && !addressed && !transmitting));

    p_pull_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_pull));

    p_addr_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addressed |-> bus_busy);

    p_send_needs_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        transmitting |-> addressed);

    p_quiet_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !sda_pull);
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_s),
    .start_c      (start_c),
    .stop_c       (stop_c),
    .sda_pull     (sda_pull),
    .addressed    (addressed),
    .transmitting (transmitting),
    .bus_busy     (bus_busy)
);

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
    localparam int Q = 6;
    localparam logic [6:0] OWN = 7'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_pull, addressed, transmitting, bus_busy;
    logic [7:0] rx_data;
    logic       sda_bus;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_addr_slave u_i2c_addr_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .own_addr     (OWN),
        .tx_byte      (tx_byte),
        .sda_pull     (sda_pull),
        .addressed    (addressed),
        .transmitting (transmitting),
        .bus_busy     (bus_busy),
        .rx_data      (rx_data)
    );

    function automatic bit exp_match(input logic [7:0] a);
        return a[7:1] == OWN;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; q();
        scl_m = 1'b1; q(); q();
        scl_m = 1'b0; q();
    endtask

    // master releases the line and reads it twice during the high phase
    task automatic get_bit(output logic early, output logic late);
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        early = sda_bus; q();
        late = sda_bus;
        scl_m = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic e, l;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(e, l);
        acked = !e && !l;
    endtask

    task automatic recv_byte(input logic [7:0] nxt, input bit nack, output logic [7:0] b);
        logic e, l;
        for (int i = 7; i >= 0; i--) begin
            get_bit(e, l);
            b[i] = l;
        end
        tx_byte = nxt;
        put_bit(nack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit         ack;
        logic [7:0] got;
        logic [7:0] a;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!bus_busy && !addressed && !transmitting && !sda_pull, "R1 reset state",
            {bus_busy, addressed, transmitting, sda_pull}, 0);
        rst_n = 1'b1;
        q();

        // directed write to own address
        bus_start();
        chk(bus_busy && !transmitting && !addressed, "R2 start status",
            {bus_busy, transmitting, addressed}, 3'b100);
        send_byte({OWN, 1'b0}, ack);
        chk(ack, "R3 address ack", ack, 1);
        chk(addressed, "R3 addressed flag", addressed, 1);
        chk(!transmitting, "R4 write direction", transmitting, 0);
        send_byte(8'hA5, ack);
        chk(ack, "R6 data ack", ack, 1);
        chk(rx_data == 8'hA5, "R6 rx_data", rx_data, 8'hA5);

        // repeated start in the middle of a byte, then read
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        tx_byte = 8'h3C;
        bus_start();
        chk(bus_busy && !addressed && !transmitting, "R10 restart clears",
            {bus_busy, addressed, transmitting}, 3'b100);
        send_byte({OWN, 1'b1}, ack);
        chk(ack && rx_data == {OWN, 1'b1}, "R10 new address taken", rx_data, {OWN, 1'b1});
        chk(transmitting, "R4 read direction", transmitting, 1);
        recv_byte(8'hC1, 1'b0, got);
        chk(got == 8'h3C, "R7 first byte", got, 8'h3C);
        recv_byte(8'h00, 1'b1, got);
        chk(got == 8'hC1, "R7 byte after master ack", got, 8'hC1);
        chk(!sda_pull, "R8 released after nack", sda_pull, 0);
        recv_byte(8'h00, 1'b1, got);
        chk(got == 8'hFF, "R8 no drive after nack", got, 8'hFF);
        bus_stop();
        chk(!bus_busy && !addressed && !transmitting, "R9 stop clears",
            {bus_busy, addressed, transmitting}, 0);

        // directed mismatch
        bus_start();
        send_byte({OWN ^ 7'h01, 1'b0}, ack);
        chk(!ack && !addressed, "R5 mismatch no ack", {ack, addressed}, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R5 data ignored", ack, 0);
        bus_stop();

        // random transactions
        for (int t = 0; t < 24; t++) begin
            int   n;
            bit   rw;
            logic [7:0] d, nx;
            a  = $urandom() % 2 ? {OWN, 1'b0} : {7'($urandom()), 1'b0};
            rw = 1'($urandom());
            a[0] = rw;
            n  = 1 + ($urandom() % 3);
            d  = 8'($urandom());
            tx_byte = d;
            bus_start();
            send_byte(a, ack);
            chk(ack == exp_match(a), "R3 R5 random address ack", ack, exp_match(a));
            chk(addressed == exp_match(a), "R3 random addressed", addressed, exp_match(a));
            if (exp_match(a))
                chk(transmitting == rw, "R4 random direction", transmitting, rw);
            for (int k = 0; k < n; k++) begin
                if (!rw) begin
                    d = 8'($urandom());
                    send_byte(d, ack);
                    chk(ack == exp_match(a), "R6 R5 random data ack", ack, exp_match(a));
                    if (exp_match(a)) chk(rx_data == d, "R6 random rx_data", rx_data, d);
                end else begin
                    nx = 8'($urandom());
                    recv_byte(nx, k == n - 1, got);
                    if (exp_match(a)) chk(got == d, "R7 random tx byte", got, d);
                    else chk(got == 8'hFF, "R5 random read idle", got, 8'hFF);
                    d = nx;
                end
            end
            bus_stop();
            chk(!bus_busy && !addressed, "R9 random stop", {bus_busy, addressed}, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule